// File: doc/BRIEF.md
# Amplifier Control Register Block

This block is the digital front of an on-chip amplifier. It holds three word-addressed registers: a control word at offset 0x00, a trim word for normal power at 0x04 and a trim word for low power at 0x08. A simple bus writes these registers on a clock edge and reads them back combinationally. From the stored fields it drives the static controls of the analog macro: enable, power level, amplifier configuration, gain, input routing, calibration controls and the 10-bit offset trim code that is actually applied.

The block decodes its fields into one of five operating states. OFF (enable low) raises the output-tristate control. RUN_NORM and RUN_LP are functional operation at normal or low power. CAL_NORM and CAL_LP are calibration at normal or low power: they raise the open-all-switches control and pass the comparator result into the read-back. Every transition between states comes from a write to the control word. The enable bit moves OFF to RUN or CAL and back. The calibration bit moves RUN to CAL and back. The low-power bit moves between the NORM and LP variants, and only while the block is in OFF. The supply-range bit and the low-power bit are locked while the amplifier is enabled.

The trim words reset to factory codes taken from input ports. A user-trim bit selects between these factory codes and the user trim words. The low-power bit picks which pair of codes applies.

Top module: `amp_ctrl_regs`

## Requirements
- R1: While reset is asserted and after it is released, the control word reads 0. Each trim word reads the factory codes on the fac_* ports, with the P code in bits 12:8 and the N code in bits 4:0.
- R2: In a trim word, only bits 12:8 (P code) and bits 4:0 (N code) are stored. All other bits read 0 and ignore writes.
- R3: The control word fields sit at these positions: enable bit 0, low power bit 1, mode bits 3:2, gain bits 5:4, inverting select bits 9:8, non-inverting select bit 10, calibration on bit 12, calibration select bit 13, user trim bit 14, comparator bit 15, supply range bit 31. Bits 30:16, 11 and 7:6 read 0.
- R4: A write to the control word changes bit 31 and bit 1 only if enable was 0 before that write. Otherwise those two fields keep their values, and the other fields of the same write still take effect.
- R5: Bit 15 of the control word is read-only. It equals cmp_in while enable=1 and calibration=1, and reads 0 otherwise.
- R6: trim_code is {P,N}. With user trim 0 it takes the factory codes of the normal or low-power pair, chosen by the low-power bit. With user trim 1 it takes the normal-mode trim word when low power is 0, and the low-power trim word when low power is 1.
- R7: out_hiz is 1 exactly when enable=0. sw_open is 1 exactly when enable=1 and calibration=1.
- R8: cfg_err is 1 when the inverting select is 01, or when bit 9 of the inverting select is 1 and the mode is not 2 (PGA).
- R9: A write appears in the registers and outputs after the next rising clock edge. Offsets other than 0x00, 0x04 and 0x08 read 0, and writes to them change nothing.
- R10: amp_en, amp_lowpwr, amp_mode, amp_gain, inv_sel, noninv_sel, cal_en, cal_sel and range_hi always equal their stored control-word fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| fac_norm_p | input | 5 | Factory P code, normal power |
| fac_norm_n | input | 5 | Factory N code, normal power |
| fac_lp_p | input | 5 | Factory P code, low power |
| fac_lp_n | input | 5 | Factory N code, low power |
| cmp_in | input | 1 | Calibration comparator result |
| amp_en | output | 1 | Amplifier enable |
| amp_lowpwr | output | 1 | Low-power select |
| amp_mode | output | 2 | Configuration mode |
| amp_gain | output | 2 | Gain select |
| inv_sel | output | 2 | Inverting input routing |
| noninv_sel | output | 1 | Non-inverting source (0 pin, 1 DAC) |
| cal_en | output | 1 | Calibration on |
| cal_sel | output | 1 | NMOS/PMOS calibration select |
| range_hi | output | 1 | Supply range select |
| out_hiz | output | 1 | Output tristate control |
| sw_open | output | 1 | Open-all-switches control |
| cfg_err | output | 1 | Illegal routing configuration |
| trim_code | output | 10 | Applied trim {P,N} |

## Verification
Two functions can meet in one write: an enable change and an attempt to change the locked range and low-power fields. The lock must use the enable value from before the edge. The bench provokes this with directed writes that set enable together with new range and power values, that clear enable while trying to change them, and that rewrite them while enable stays high. It adds random control words with random enable bits. After each edge, a bench model that applies the lock using the old enable judges the read-back, the trim_code selection and every control output.

// File: rtl/amp_ctrl_pkg.sv
package amp_ctrl_pkg;
    localparam logic [3:0] OFF_CTL  = 4'h0;
    localparam logic [3:0] OFF_TNRM = 4'h4;
    localparam logic [3:0] OFF_TLP  = 4'h8;

    localparam logic [1:0] MODE_PGA = 2'd2;
    localparam logic [1:0] INV_RSVD = 2'b01;

    localparam int B_EN     = 0;
    localparam int B_LPM    = 1;
    localparam int B_MODE   = 2;
    localparam int B_GAIN   = 4;
    localparam int B_INV    = 8;
    localparam int B_NINV   = 10;
    localparam int B_CALON  = 12;
    localparam int B_CALSEL = 13;
    localparam int B_USER   = 14;
    localparam int B_CMP    = 15;
    localparam int B_P_LSB  = 8;

    typedef struct packed {
        logic       range;
        logic       user;
        logic       calsel;
        logic       calon;
        logic       ninv;
        logic [1:0] inv;
        logic [1:0] gain;
        logic [1:0] mode;
        logic       lpm;
        logic       en;
    } ctl_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN_NORM,
        ST_RUN_LP,
        ST_CAL_NORM,
        ST_CAL_LP
    } op_state_e;
endpackage

// File: rtl/amp_csr_reg.sv
module amp_csr_reg
    import amp_ctrl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl
);
    localparam int B_RANGE = DATA_W - 1;

    ctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q.en     <= wdata[B_EN];
            ctl_q.mode   <= wdata[B_MODE +: 2];
            ctl_q.gain   <= wdata[B_GAIN +: 2];
            ctl_q.inv    <= wdata[B_INV +: 2];
            ctl_q.ninv   <= wdata[B_NINV];
            ctl_q.calon  <= wdata[B_CALON];
            ctl_q.calsel <= wdata[B_CALSEL];
            ctl_q.user   <= wdata[B_USER];
            if (!ctl_q.en) begin
                ctl_q.range <= wdata[B_RANGE];
                ctl_q.lpm   <= wdata[B_LPM];
            end
        end
    end

    assign ctl = ctl_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[B_RANGE-1:B_CMP], wdata[11], wdata[7:6]};

    // R4
    range_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.en |=> ($stable(ctl_q.range) && $stable(ctl_q.lpm)));
endmodule

// File: rtl/amp_trim_reg.sv
module amp_trim_reg #(
    parameter int TRIM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TRIM_W-1:0] wr_p,
    input  logic [TRIM_W-1:0] wr_n,
    input  logic [TRIM_W-1:0] fac_p,
    input  logic [TRIM_W-1:0] fac_n,
    output logic [TRIM_W-1:0] code_p,
    output logic [TRIM_W-1:0] code_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_p <= fac_p;
            code_n <= fac_n;
        end else if (wr_en) begin
            code_p <= wr_p;
            code_n <= wr_n;
        end
    end
endmodule

// File: rtl/amp_mode_decode.sv
module amp_mode_decode
    import amp_ctrl_pkg::*;
#(
    parameter int TRIM_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ctl_t                ctl,
    input  logic                cmp_in,
    input  logic [TRIM_W-1:0]   fac_norm_p,
    input  logic [TRIM_W-1:0]   fac_norm_n,
    input  logic [TRIM_W-1:0]   fac_lp_p,
    input  logic [TRIM_W-1:0]   fac_lp_n,
    input  logic [TRIM_W-1:0]   usr_norm_p,
    input  logic [TRIM_W-1:0]   usr_norm_n,
    input  logic [TRIM_W-1:0]   usr_lp_p,
    input  logic [TRIM_W-1:0]   usr_lp_n,
    output logic                out_hiz,
    output logic                sw_open,
    output logic                cal_out,
    output logic                cfg_err,
    output logic [2*TRIM_W-1:0] trim_code
);
    op_state_e state;

    always_comb begin
        if (!ctl.en)        state = ST_OFF;
        else if (ctl.calon) state = ctl.lpm ? ST_CAL_LP : ST_CAL_NORM;
        else                state = ctl.lpm ? ST_RUN_LP : ST_RUN_NORM;
    end

    always_comb begin
        out_hiz = 1'b0;
        sw_open = 1'b0;
        cal_out = 1'b0;
        unique case (state)
            ST_OFF:                  out_hiz = 1'b1;
            ST_RUN_NORM, ST_RUN_LP:  ;
            ST_CAL_NORM, ST_CAL_LP: begin
                sw_open = 1'b1;
                cal_out = cmp_in;
            end
            default:                 out_hiz = 1'b1;
        endcase
    end

    always_comb begin
        unique case ({ctl.user, ctl.lpm})
            2'b00:   trim_code = {fac_norm_p, fac_norm_n};
            2'b01:   trim_code = {fac_lp_p, fac_lp_n};
            2'b10:   trim_code = {usr_norm_p, usr_norm_n};
            default: trim_code = {usr_lp_p, usr_lp_n};
        endcase
    end

    always_comb begin
        cfg_err = (ctl.inv == INV_RSVD) || (ctl.inv[1] && (ctl.mode != MODE_PGA));
    end

    // R7
    hiz_cal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_hiz, sw_open}));
    // R5
    calout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_open |-> !cal_out);
endmodule

// File: rtl/amp_ctrl_regs.sv
module amp_ctrl_regs
    import amp_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int TRIM_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [TRIM_W-1:0]   fac_norm_p,
    input  logic [TRIM_W-1:0]   fac_norm_n,
    input  logic [TRIM_W-1:0]   fac_lp_p,
    input  logic [TRIM_W-1:0]   fac_lp_n,
    input  logic                cmp_in,
    output logic                amp_en,
    output logic                amp_lowpwr,
    output logic [1:0]          amp_mode,
    output logic [1:0]          amp_gain,
    output logic [1:0]          inv_sel,
    output logic                noninv_sel,
    output logic                cal_en,
    output logic                cal_sel,
    output logic                range_hi,
    output logic                out_hiz,
    output logic                sw_open,
    output logic                cfg_err,
    output logic [2*TRIM_W-1:0] trim_code
);
    localparam int CTL_PAD  = DATA_W - 17;
    localparam int TRIM_TOP = DATA_W - B_P_LSB - TRIM_W;
    localparam int TRIM_GAP = B_P_LSB - TRIM_W;

    ctl_t              ctl;
    logic              cal_out;
    logic [TRIM_W-1:0] nrm_p, nrm_n, lp_p, lp_n;
    logic              hit_ctl, hit_nrm, hit_lp;

    assign hit_ctl = (bus_addr == ADDR_W'(OFF_CTL));
    assign hit_nrm = (bus_addr == ADDR_W'(OFF_TNRM));
    assign hit_lp  = (bus_addr == ADDR_W'(OFF_TLP));

    amp_csr_reg #(.DATA_W(DATA_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit_ctl),
        .wdata(bus_wdata), .ctl(ctl)
    );

    amp_trim_reg #(.TRIM_W(TRIM_W)) u_trim_nrm (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit_nrm),
        .wr_p(bus_wdata[B_P_LSB +: TRIM_W]), .wr_n(bus_wdata[TRIM_W-1:0]),
        .fac_p(fac_norm_p), .fac_n(fac_norm_n),
        .code_p(nrm_p), .code_n(nrm_n)
    );

    amp_trim_reg #(.TRIM_W(TRIM_W)) u_trim_lp (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit_lp),
        .wr_p(bus_wdata[B_P_LSB +: TRIM_W]), .wr_n(bus_wdata[TRIM_W-1:0]),
        .fac_p(fac_lp_p), .fac_n(fac_lp_n),
        .code_p(lp_p), .code_n(lp_n)
    );

    amp_mode_decode #(.TRIM_W(TRIM_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .cmp_in(cmp_in),
        .fac_norm_p(fac_norm_p), .fac_norm_n(fac_norm_n),
        .fac_lp_p(fac_lp_p), .fac_lp_n(fac_lp_n),
        .usr_norm_p(nrm_p), .usr_norm_n(nrm_n),
        .usr_lp_p(lp_p), .usr_lp_n(lp_n),
        .out_hiz(out_hiz), .sw_open(sw_open), .cal_out(cal_out),
        .cfg_err(cfg_err), .trim_code(trim_code)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_ctl) begin
            bus_rdata = {ctl.range, {CTL_PAD{1'b0}}, cal_out, ctl.user, ctl.calsel,
                         ctl.calon, 1'b0, ctl.ninv, ctl.inv, 2'b00, ctl.gain,
                         ctl.mode, ctl.lpm, ctl.en};
        end else if (hit_nrm) begin
            bus_rdata = {{TRIM_TOP{1'b0}}, nrm_p, {TRIM_GAP{1'b0}}, nrm_n};
        end else if (hit_lp) begin
            bus_rdata = {{TRIM_TOP{1'b0}}, lp_p, {TRIM_GAP{1'b0}}, lp_n};
        end
    end

    assign amp_en     = ctl.en;
    assign amp_lowpwr = ctl.lpm;
    assign amp_mode   = ctl.mode;
    assign amp_gain   = ctl.gain;
    assign inv_sel    = ctl.inv;
    assign noninv_sel = ctl.ninv;
    assign cal_en     = ctl.calon;
    assign cal_sel    = ctl.calsel;
    assign range_hi   = ctl.range;

    // R2
    trim_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_nrm || hit_lp) |-> (bus_rdata[DATA_W-1:B_P_LSB+TRIM_W] == '0
                                 && bus_rdata[B_P_LSB-1:TRIM_W] == '0));
    // R5
    calout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctl && !(amp_en && cal_en)) |-> !bus_rdata[B_CMP]);
    // R8
    cfg_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (inv_sel != 2'b00));
    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_ctl && !hit_nrm && !hit_lp) |=>
        ($stable(amp_en) && $stable(amp_mode) && $stable(inv_sel) && $stable(range_hi)));
endmodule

// File: tb/amp_ctrl_regs_test.sv
`timescale 1ns/100ps
module amp_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  fac_norm_p = 5'h0A, fac_norm_n = 5'h15;
    logic [4:0]  fac_lp_p = 5'h03, fac_lp_n = 5'h1C;
    logic        cmp_in = 1'b0;
    logic        amp_en, amp_lowpwr, noninv_sel, cal_en, cal_sel, range_hi;
    logic [1:0]  amp_mode, amp_gain, inv_sel;
    logic        out_hiz, sw_open, cfg_err;
    logic [9:0]  trim_code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model
    logic m_range, m_user, m_calsel, m_calon, m_ninv, m_lpm, m_en;
    logic [1:0] m_inv, m_gain, m_mode;
    logic [4:0] m_np, m_nn, m_lp, m_ln;

    always #4 clk = ~clk;

    amp_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fac_norm_p(fac_norm_p), .fac_norm_n(fac_norm_n),
        .fac_lp_p(fac_lp_p), .fac_lp_n(fac_lp_n), .cmp_in(cmp_in),
        .amp_en(amp_en), .amp_lowpwr(amp_lowpwr), .amp_mode(amp_mode),
        .amp_gain(amp_gain), .inv_sel(inv_sel), .noninv_sel(noninv_sel),
        .cal_en(cal_en), .cal_sel(cal_sel), .range_hi(range_hi),
        .out_hiz(out_hiz), .sw_open(sw_open), .cfg_err(cfg_err),
        .trim_code(trim_code)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctl();
        return {m_range, 15'b0, m_en & m_calon & cmp_in, m_user, m_calsel, m_calon,
                1'b0, m_ninv, m_inv, 2'b00, m_gain, m_mode, m_lpm, m_en};
    endfunction

    function automatic logic [31:0] exp_trim(input logic [4:0] p, input logic [4:0] n);
        return {19'b0, p, 3'b000, n};
    endfunction

    function automatic logic [9:0] exp_code();
        if (!m_user) return m_lpm ? {fac_lp_p, fac_lp_n} : {fac_norm_p, fac_norm_n};
        return m_lpm ? {m_lp, m_ln} : {m_np, m_nn};
    endfunction

    function automatic logic exp_err();
        return (m_inv == 2'b01) || (m_inv[1] && m_mode != 2'd2);
    endfunction

    task automatic model_reset();
        {m_range, m_user, m_calsel, m_calon, m_ninv, m_lpm, m_en} = '0;
        m_inv = 0; m_gain = 0; m_mode = 0;
        m_np = fac_norm_p; m_nn = fac_norm_n; m_lp = fac_lp_p; m_ln = fac_lp_n;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        if (a == 4'h0) begin
            if (!m_en) begin
                m_range = d[31];
                m_lpm   = d[1];
            end
            m_en = d[0]; m_mode = d[3:2]; m_gain = d[5:4]; m_inv = d[9:8];
            m_ninv = d[10]; m_calon = d[12]; m_calsel = d[13]; m_user = d[14];
        end else if (a == 4'h4) begin
            m_np = d[12:8]; m_nn = d[4:0];
        end else if (a == 4'h8) begin
            m_lp = d[12:8]; m_ln = d[4:0];
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // called in the low clock phase
    task automatic check_all(input string tag);
        bus_addr = 4'h0; #0.5;
        chk(bus_rdata == exp_ctl(), {tag, " R3 R5 ctl word"}, bus_rdata, exp_ctl());
        bus_addr = 4'h4; #0.5;
        chk(bus_rdata == exp_trim(m_np, m_nn), {tag, " R2 normal trim"}, bus_rdata,
            exp_trim(m_np, m_nn));
        bus_addr = 4'h8; #0.5;
        chk(bus_rdata == exp_trim(m_lp, m_ln), {tag, " R2 lp trim"}, bus_rdata,
            exp_trim(m_lp, m_ln));
        bus_addr = 4'hC; #0.5;
        chk(bus_rdata == 32'h0, {tag, " R9 unmapped read"}, bus_rdata, 32'h0);
        chk(trim_code == exp_code(), {tag, " R6 trim_code"}, 32'(trim_code),
            32'(exp_code()));
        chk({out_hiz, sw_open} == {!m_en, m_en & m_calon}, {tag, " R7 hiz/sw_open"},
            32'({out_hiz, sw_open}), 32'({!m_en, m_en & m_calon}));
        chk(cfg_err == exp_err(), {tag, " R8 cfg_err"}, 32'(cfg_err), 32'(exp_err()));
        chk({amp_en, amp_lowpwr, amp_mode, amp_gain, inv_sel, noninv_sel, cal_en, cal_sel,
             range_hi} == {m_en, m_lpm, m_mode, m_gain, m_inv, m_ninv, m_calon, m_calsel,
             m_range}, {tag, " R10 control outputs"},
            32'({amp_en, amp_lowpwr, amp_mode, amp_gain, inv_sel, noninv_sel, cal_en,
                 cal_sel, range_hi}),
            32'({m_en, m_lpm, m_mode, m_gain, m_inv, m_ninv, m_calon, m_calsel, m_range}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] addrs [5];
        void'($urandom(32'h5EED));
        addrs[0] = 4'h0; addrs[1] = 4'h4; addrs[2] = 4'h8; addrs[3] = 4'hC; addrs[4] = 4'h6;
        model_reset();
        // R1 reset state while reset held and after release
        repeat (2) @(negedge clk);
        check_all("r1_during_reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2 trim word masks
        wr(4'h4, 32'hFFFF_FFFF); check_all("R2 all ones normal");
        wr(4'h8, 32'hFFFF_E0E0); check_all("R2 reserved only lp");

        // R6 user trim, both power levels
        wr(4'h0, 32'h0000_4000); check_all("R6 user normal");
        wr(4'h0, 32'h0000_4002); check_all("R6 user lp");
        wr(4'h0, 32'h0000_0002); check_all("R6 factory lp");

        // R4 lock: enable together with range/lpm change (enable was 0 -> allowed)
        wr(4'h0, 32'h8000_0001); check_all("R4 set with enable");
        chk(range_hi == 1'b1 && amp_lowpwr == 1'b0, "R4 change while off",
            32'({range_hi, amp_lowpwr}), 32'h2);
        wr(4'h0, 32'h0000_0003); check_all("R4 locked while on");
        chk(range_hi == 1'b1 && amp_lowpwr == 1'b0, "R4 fields held",
            32'({range_hi, amp_lowpwr}), 32'h2);
        wr(4'h0, 32'h0000_0002); check_all("R4 disable blocks lpm");
        wr(4'h0, 32'h0000_0002); check_all("R4 now allowed");

        // R5 comparator gating
        wr(4'h0, 32'h0000_3001);
        cmp_in = 1'b1; check_all("R5 cal on cmp1");
        cmp_in = 1'b0; check_all("R5 cal on cmp0");
        wr(4'h0, 32'h0000_8001);
        cmp_in = 1'b1; check_all("R5 cal off, bit15 write ignored");
        wr(4'h0, 32'h0000_1000); check_all("R5 R7 cal without enable");

        // R8 routing legality
        wr(4'h0, 32'h0000_0100); check_all("R8 reserved select");
        wr(4'h0, 32'h0000_0208); check_all("R8 1x with pga");
        wr(4'h0, 32'h0000_030C); check_all("R8 1x with follower");
        wr(4'h0, 32'h0000_0000); check_all("R8 pin route");

        // R9 write visible only after the edge; unmapped writes ignored
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0000_0035;
        #1;
        chk(bus_rdata == exp_ctl(), "R9 before edge", bus_rdata, exp_ctl());
        @(posedge clk); model_write(4'h0, 32'h0000_0035);
        @(negedge clk); bus_wr = 1'b0;
        check_all("R9 after edge");
        wr(4'hC, 32'hFFFF_FFFF); check_all("R9 unmapped write C");
        wr(4'h6, 32'hFFFF_FFFF); check_all("R9 unmapped write 6");

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            logic [3:0]  a;
            a = addrs[$urandom % 5];
            d = $urandom;
            if ($urandom % 3 == 0) d[0] = 1'b0;
            cmp_in = 1'($urandom);
            wr(a, d);
            check_all("rand R4 R6");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule